// File: doc/BRIEF.md
# Multiplexed-Bus Burst Read Sequencer

This block is the device-side control for a NOR-style memory whose address and data share one 16-bit bus. It samples the chip-select, read-enable, write, address-strobe, hardware-reset and burst-clock pins with a fast internal clock. From their levels and edges it works out which bus operation is in progress. It keeps a 22-bit word address: the low 16 bits come from the shared bus and the high 6 bits from dedicated lines. It drives that address to an external synchronous array that answers one internal clock later.

Out of reset the block serves asynchronous reads. The address is taken when the strobe rises and is driven back only while read-enable is low. The first burst-clock rising edge seen with the strobe low switches the block into burst mode and loads a start address. After a programmable number of wait edges, each further burst-clock edge presents the next word. The sequence is either a plain incrementing run or a wrap inside an aligned 8-, 16- or 32-word window. A strobe cycle with the write pin low sends a command. One command sets the burst length and the wait count. Another turns on a sticky power-save flag that only the hardware reset pin clears.

Top module: `mux_burst_rd`

## Requirements
- R1: After reset the bus is not driven, `rdy` is 0, `ps_mode` is 0, and the block is in asynchronous mode.
- R2: While `cs_n` is high, `adq_oe` and `rdy` are 0 regardless of every other pin.
- R3: In asynchronous mode a rising `astb_n` with `cs_n` low and `wr_n` high captures the address {`a_hi`,`adq_i`}. After that, `rdy` is 1 and the array word is driven on `adq_o` only while `rd_en_n` is low.
- R4: A command write is a rising `astb_n` with `wr_n` low, followed by a rising `wr_n`, with `cs_n` low throughout. The bus value at the `wr_n` rise is the command. A command with bits 15:8 = 0xC5 loads the burst length from bits 4:3 (0 incrementing, 1 wrap-8, 2 wrap-16, 3 wrap-32) and the wait code from bits 2:0, giving code+2 wait edges. The defaults are incrementing with 9 wait edges.
- R5: A rising `burst_clk` with `astb_n` low and `cs_n` low enters burst mode and loads the start address. With W wait edges configured, `rdy` stays 0 after the next W-1 rising edges and the start word appears after the W-th.
- R6: In incrementing mode each later rising `burst_clk` with `astb_n` high advances the address by one. 0x3FFFFF is followed by 0x000000.
- R7: In wrap-N mode the low log2(N) address bits count modulo N and the upper bits stay fixed.
- R8: `cs_n` high ends a burst. Later clock edges with `astb_n` high and `cs_n` low again produce no data until a new start address is loaded.
- R9: Loading a new start address during a burst abandons the old sequence and restarts the full wait count at the new address.
- R10: `hw_reset_n` low returns the block to asynchronous mode, restores the configuration defaults and clears `ps_mode`.
- R11: The command 0x00A5 sets `ps_mode`. Later commands leave it set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal sampling clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| hw_reset_n | input | 1 | Hardware reset pin, active low |
| cs_n | input | 1 | Chip select, active low |
| rd_en_n | input | 1 | Output enable, active low |
| wr_n | input | 1 | Write strobe, active low |
| astb_n | input | 1 | Address strobe, active low |
| burst_clk | input | 1 | Burst clock pin |
| a_hi | input | 6 | Upper address lines |
| adq_i | input | 16 | Shared bus, input side |
| adq_o | output | 16 | Shared bus, output side |
| adq_oe | output | 1 | Shared bus drive enable |
| rdy | output | 1 | Valid word available |
| ps_mode | output | 1 | Power-save flag |
| mem_addr | output | 22 | Word address to the array |
| mem_rdata | input | 16 | Array read data, one `clk` after `mem_addr` |

## Verification
The hardest situations to reach are the restart and the termination. In each, burst state is left behind that a careless design would carry on with: a stale wait count or a stale address pointer. The stimulus starts a new strobe-low clock edge while an earlier wrap-32 burst is still delivering words. It also drops and reselects the chip in the middle of a burst and then clocks with the strobe high. The wrap and rollover cases use start addresses a few words below a window or array boundary, so the boundary is crossed within a handful of edges.

// File: rtl/mux_burst_rd_pkg.sv
package mux_burst_rd_pkg;
  typedef enum logic [1:0] {
    BL_INC  = 2'd0,
    BL_W8   = 2'd1,
    BL_W16  = 2'd2,
    BL_W32  = 2'd3
  } blen_e;

  localparam logic [7:0]  CFG_KEY = 8'hC5;
  localparam logic [15:0] PS_CMD  = 16'h00A5;
endpackage

// File: rtl/mux_burst_sync.sv
module mux_burst_sync #(
  parameter int unsigned W = 8,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= RST_VAL;
      q    <= RST_VAL;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/mux_burst_cmd.sv
module mux_burst_cmd
  import mux_burst_rd_pkg::*;
#(
  parameter int unsigned DW  = 16,
  parameter int unsigned WSW = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           hw_rst,
  input  logic           wr_en,
  input  logic [DW-1:0]  wr_data,
  output blen_e          blen,
  output logic [WSW-1:0] ws_code,
  output logic           ps_mode
);
  logic           cfg_hit, ps_hit;
  blen_e          blen_d;
  logic [WSW-1:0] ws_d;
  logic           ps_d;

  assign cfg_hit = wr_en && (wr_data[15:8] == CFG_KEY);
  assign ps_hit  = wr_en && (wr_data == PS_CMD);

  always_comb begin
    blen_d = blen;
    ws_d   = ws_code;
    ps_d   = ps_mode;
    if (hw_rst) begin
      blen_d = BL_INC;
      ws_d   = '1;
      ps_d   = 1'b0;
    end else begin
      if (cfg_hit) begin
        blen_d = blen_e'(wr_data[4:3]);
        ws_d   = wr_data[WSW-1:0];
      end
      if (ps_hit) ps_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blen    <= BL_INC;
      ws_code <= '1;
      ps_mode <= 1'b0;
    end else begin
      blen    <= blen_d;
      ws_code <= ws_d;
      ps_mode <= ps_d;
    end
  end

  a_r11_ps_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ps_mode && !hw_rst) |=> ps_mode);
  a_r4_cfg_default: assert property (@(posedge clk) disable iff (!rst_n)
    hw_rst |=> (blen == BL_INC) && (ws_code == '1));
endmodule

// File: rtl/mux_burst_agen.sv
module mux_burst_agen
  import mux_burst_rd_pkg::*;
#(
  parameter int unsigned AW = 22
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          load,
  input  logic          step,
  input  logic [AW-1:0] start,
  input  blen_e         blen,
  output logic [AW-1:0] addr
);
  logic [AW-1:0] wmask, inc, addr_d;

  always_comb begin
    case (blen)
      BL_W8:   wmask = AW'(7);
      BL_W16:  wmask = AW'(15);
      BL_W32:  wmask = AW'(31);
      default: wmask = '1;
    endcase
  end

  assign inc = addr + AW'(1);

  always_comb begin
    addr_d = addr;
    if (clr)       addr_d = '0;
    else if (load) addr_d = start;
    else if (step) addr_d = (addr & ~wmask) | (inc & wmask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) addr <= '0;
    else        addr <= addr_d;
  end

  a_r6_inc_step: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !clr && !load && blen == BL_INC) |=> addr == $past(addr) + AW'(1));
  a_r7_window_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !clr && !load && blen != BL_INC) |=> (addr[AW-1:5] == $past(addr[AW-1:5])));
endmodule

// File: rtl/mux_burst_rd.sv
module mux_burst_rd
  import mux_burst_rd_pkg::*;
#(
  parameter int unsigned AW  = 22,
  parameter int unsigned DW  = 16,
  parameter int unsigned WSW = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hw_reset_n,
  input  logic             cs_n,
  input  logic             rd_en_n,
  input  logic             wr_n,
  input  logic             astb_n,
  input  logic             burst_clk,
  input  logic [AW-DW-1:0] a_hi,
  input  logic [DW-1:0]    adq_i,
  output logic [DW-1:0]    adq_o,
  output logic             adq_oe,
  output logic             rdy,
  output logic             ps_mode,
  output logic [AW-1:0]    mem_addr,
  input  logic [DW-1:0]    mem_rdata
);
  localparam int unsigned HIW = AW - DW;
  localparam int unsigned SW  = 6 + AW;
  localparam int unsigned CW  = WSW + 1;
  localparam logic [SW-1:0] SYNC_RST = {6'b111110, {AW{1'b0}}};

  logic [SW-1:0] s_vec;
  logic s_rst, s_cs, s_oe, s_we, s_astb, s_bclk;
  logic [HIW-1:0] s_hi;
  logic [DW-1:0]  s_bus;

  mux_burst_sync #(.W(SW), .RST_VAL(SYNC_RST)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({hw_reset_n, cs_n, rd_en_n, wr_n, astb_n, burst_clk, a_hi, adq_i}),
    .q(s_vec)
  );
  assign {s_rst, s_cs, s_oe, s_we, s_astb, s_bclk, s_hi, s_bus} = s_vec;

  logic p_bclk, p_astb, p_we;
  logic bclk_re, astb_re, we_re, hw_rst;
  assign bclk_re = s_bclk & ~p_bclk;
  assign astb_re = s_astb & ~p_astb;
  assign we_re   = s_we & ~p_we;
  assign hw_rst  = ~s_rst;

  // Sequencer state
  logic          burst_mode, bact, bvld, avld, apend, cmd_pend;
  logic [CW-1:0] wcnt;
  logic [AW-1:0] async_addr;
  logic          burst_mode_d, bact_d, bvld_d, avld_d, apend_d, cmd_pend_d;
  logic [CW-1:0] wcnt_d;
  logic [AW-1:0] async_addr_d;

  blen_e          blen;
  logic [WSW-1:0] ws_code;
  logic           load, step, wr_cmd;
  logic [AW-1:0]  gen_addr;

  assign load   = bclk_re & ~s_astb & ~s_cs & ~hw_rst;
  assign step   = bclk_re & s_astb & ~s_cs & bact & bvld & ~hw_rst;
  assign wr_cmd = we_re & ~s_cs & cmd_pend & ~hw_rst;

  mux_burst_cmd #(.DW(DW), .WSW(WSW)) u_cmd (
    .clk(clk), .rst_n(rst_n), .hw_rst(hw_rst),
    .wr_en(wr_cmd), .wr_data(s_bus),
    .blen(blen), .ws_code(ws_code), .ps_mode(ps_mode)
  );

  mux_burst_agen #(.AW(AW)) u_agen (
    .clk(clk), .rst_n(rst_n), .clr(hw_rst),
    .load(load), .step(step), .start({s_hi, s_bus}),
    .blen(blen), .addr(gen_addr)
  );

  always_comb begin
    burst_mode_d = burst_mode;
    bact_d       = bact;
    bvld_d       = bvld;
    wcnt_d       = wcnt;
    avld_d       = avld;
    apend_d      = 1'b0;
    cmd_pend_d   = cmd_pend;
    async_addr_d = async_addr;
    if (hw_rst) begin
      burst_mode_d = 1'b0;
      bact_d       = 1'b0;
      bvld_d       = 1'b0;
      wcnt_d       = '0;
      avld_d       = 1'b0;
      cmd_pend_d   = 1'b0;
    end else begin
      if (load) begin
        burst_mode_d = 1'b1;
        bact_d       = 1'b1;
        bvld_d       = 1'b0;
        avld_d       = 1'b0;
        wcnt_d       = {1'b0, ws_code} + CW'(2);
      end else if (s_cs) begin
        bact_d = 1'b0;
        bvld_d = 1'b0;
        wcnt_d = '0;
      end else if (bclk_re && bact && !bvld) begin
        if (wcnt <= CW'(1)) begin
          bvld_d = 1'b1;
          wcnt_d = '0;
        end else begin
          wcnt_d = wcnt - CW'(1);
        end
      end
      if (astb_re && !s_cs && s_we && !burst_mode) begin
        async_addr_d = {s_hi, s_bus};
        avld_d       = 1'b0;
        apend_d      = 1'b1;
      end else if (apend) begin
        avld_d = 1'b1;
      end
      if (astb_re && !s_cs && !s_we) cmd_pend_d = 1'b1;
      else if (wr_cmd)               cmd_pend_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_bclk     <= 1'b0;
      p_astb     <= 1'b1;
      p_we       <= 1'b1;
      burst_mode <= 1'b0;
      bact       <= 1'b0;
      bvld       <= 1'b0;
      wcnt       <= '0;
      avld       <= 1'b0;
      apend      <= 1'b0;
      cmd_pend   <= 1'b0;
      async_addr <= '0;
    end else begin
      p_bclk     <= s_bclk;
      p_astb     <= s_astb;
      p_we       <= s_we;
      burst_mode <= burst_mode_d;
      bact       <= bact_d;
      bvld       <= bvld_d;
      wcnt       <= wcnt_d;
      avld       <= avld_d;
      apend      <= apend_d;
      cmd_pend   <= cmd_pend_d;
      async_addr <= async_addr_d;
    end
  end

  logic data_ok;
  assign data_ok  = burst_mode ? bvld : avld;
  assign rdy      = ~s_cs & data_ok;
  assign adq_oe   = rdy & ~s_oe;
  assign adq_o    = adq_oe ? mem_rdata : '0;
  assign mem_addr = burst_mode ? gen_addr : async_addr;

  a_r5_wait_no_data: assert property (@(posedge clk) disable iff (!rst_n)
    (bclk_re && bact && !bvld && wcnt > CW'(1) && !s_cs && s_astb && !hw_rst) |=> !bvld);
  a_r9_reload: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (bact && !bvld && wcnt == {1'b0, $past(ws_code)} + CW'(2)));
  a_r8_cs_end: assert property (@(posedge clk) disable iff (!rst_n)
    (s_cs && !hw_rst) |=> (!bact && !bvld));
  a_r10_hw_rst: assert property (@(posedge clk) disable iff (!rst_n)
    hw_rst |=> (!burst_mode && !rdy));
endmodule

// File: tb/mux_burst_rd_bench.sv
module mux_burst_rd_bench;
  typedef struct {
    logic        rdy;
    logic        oe;
    logic [15:0] d;
    string       tag;
  } exp_t;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, hw_reset_n, cs_n, rd_en_n, wr_n, astb_n, burst_clk;
  logic [5:0]  a_hi;
  logic [15:0] adq_i, adq_o, mem_rdata;
  logic        adq_oe, rdy, ps_mode;
  logic [21:0] mem_addr;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  exp_t exp_q[$];

  mux_burst_rd u_mux_burst_rd (
    .clk(clk), .rst_n(rst_n), .hw_reset_n(hw_reset_n), .cs_n(cs_n),
    .rd_en_n(rd_en_n), .wr_n(wr_n), .astb_n(astb_n), .burst_clk(burst_clk),
    .a_hi(a_hi), .adq_i(adq_i), .adq_o(adq_o), .adq_oe(adq_oe), .rdy(rdy),
    .ps_mode(ps_mode), .mem_addr(mem_addr), .mem_rdata(mem_rdata)
  );

  function automatic logic [15:0] mem_f(input logic [21:0] a);
    return a[15:0] ^ {4'h0, a[21:16], a[21:16]};
  endfunction

  always_ff @(posedge clk) mem_rdata <= mem_f(mem_addr);

  // Monitor: pops expected items and compares against the ports
  always @(negedge clk) begin
    if (exp_q.size() != 0) begin
      exp_t e;
      e = exp_q.pop_front();
      checks++;
      if (rdy !== e.rdy || adq_oe !== e.oe || (e.oe && adq_o !== e.d)) begin
        errors++;
        $display("FAIL %s: rdy/oe/data = %b/%b/%h expected %b/%b/%h",
                 e.tag, rdy, adq_oe, adq_o, e.rdy, e.oe, e.d);
      end
    end
  end

  task automatic settle(input int n = 8);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_out(input logic r, input logic o, input logic [15:0] d, input string tag);
    exp_t e;
    e.rdy = r; e.oe = o; e.d = d; e.tag = tag;
    exp_q.push_back(e);
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  task automatic chk_ps(input logic exp, input string tag);
    checks++;
    if (ps_mode !== exp) begin
      errors++;
      $display("FAIL %s: ps_mode = %b expected %b", tag, ps_mode, exp);
    end
  endtask

  task automatic pulse_clk();
    @(negedge clk) burst_clk = 1'b1;
    settle(6);
    burst_clk = 1'b0;
    settle(6);
  endtask

  task automatic async_read(input logic [21:0] a, input string tag);
    cs_n = 1'b0; rd_en_n = 1'b1; wr_n = 1'b1; astb_n = 1'b0;
    {a_hi, adq_i} = a;
    settle();
    astb_n = 1'b1;
    settle();
    expect_out(1'b1, 1'b0, 16'h0, {tag, " read-enable high"});
    rd_en_n = 1'b0;
    settle();
    expect_out(1'b1, 1'b1, mem_f(a), {tag, " data"});
  endtask

  task automatic cmd_write(input logic [15:0] d);
    rd_en_n = 1'b1; cs_n = 1'b0; wr_n = 1'b0; astb_n = 1'b0;
    a_hi = 6'h0; adq_i = 16'h0555;
    settle();
    astb_n = 1'b1;
    settle();
    adq_i = d;
    settle();
    wr_n = 1'b1;
    settle();
  endtask

  function automatic logic [21:0] next_a(input logic [21:0] a, input logic [1:0] bl);
    logic [21:0] m;
    case (bl)
      2'd1: m = 22'd7;
      2'd2: m = 22'd15;
      2'd3: m = 22'd31;
      default: m = '1;
    endcase
    return (a & ~m) | ((a + 22'd1) & m);
  endfunction

  task automatic burst(input logic [21:0] start, input int waits, input int nwords,
                       input logic [1:0] bl, input string tag);
    logic [21:0] a;
    cs_n = 1'b0; rd_en_n = 1'b0; wr_n = 1'b1; astb_n = 1'b0;
    {a_hi, adq_i} = start;
    settle(4);
    pulse_clk();
    astb_n = 1'b1; adq_i = 16'h0;
    settle(2);
    for (int i = 1; i < waits; i++) begin
      pulse_clk();
      expect_out(1'b0, 1'b0, 16'h0, {tag, " wait edge"});
    end
    a = start;
    for (int k = 0; k < nwords; k++) begin
      pulse_clk();
      expect_out(1'b1, 1'b1, mem_f(a), {tag, " word"});
      a = next_a(a, bl);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; hw_reset_n = 1'b1; cs_n = 1'b1; rd_en_n = 1'b1; wr_n = 1'b1;
    astb_n = 1'b1; burst_clk = 1'b0; a_hi = '0; adq_i = '0;
    settle(4);
    rst_n = 1'b1;
    settle();
    // R1 reset state
    expect_out(1'b0, 1'b0, 16'h0, "R1 reset outputs");
    chk_ps(1'b0, "R1 reset ps_mode");

    // R3 asynchronous reads
    async_read(22'h2A_1234, "R3 async A");
    async_read(22'h05_BEEF, "R3 async B");
    // R2 chip deselect with read-enable still low
    cs_n = 1'b1;
    settle();
    expect_out(1'b0, 1'b0, 16'h0, "R2 deselect");

    // R4 defaults (9 waits, incrementing) and R6 rollover at the array top
    burst(22'h3F_FFFE, 9, 4, 2'd0, "R4 R5 R6 default burst rollover");

    // R4 config: wrap-8, code 1 -> 3 waits; R7 window 8..15
    cmd_write(16'hC509);
    burst(22'h15_000D, 3, 9, 2'd1, "R7 wrap8");
    // wrap-16, code 0 -> 2 waits
    cmd_write(16'hC510);
    burst(22'h01_003E, 2, 5, 2'd2, "R7 wrap16");
    // wrap-32, code 2 -> 4 waits
    cmd_write(16'hC51A);
    burst(22'h00_105E, 4, 4, 2'd3, "R7 wrap32");

    // R9 restart in mid-burst
    burst(22'h00_0100, 4, 2, 2'd3, "R9 first");
    burst(22'h00_0200, 4, 2, 2'd3, "R9 restart");

    // R8 termination by deselect
    cs_n = 1'b1;
    settle();
    expect_out(1'b0, 1'b0, 16'h0, "R8 deselect ends burst");
    cs_n = 1'b0;
    settle();
    pulse_clk();
    expect_out(1'b0, 1'b0, 16'h0, "R8 no resume edge 1");
    pulse_clk();
    expect_out(1'b0, 1'b0, 16'h0, "R8 no resume edge 2");

    // R11 sticky power-save flag
    cmd_write(16'h00A5);
    chk_ps(1'b1, "R11 set");
    cmd_write(16'hC500);
    chk_ps(1'b1, "R11 survives config write");

    // R10 hardware reset
    cs_n = 1'b1;
    hw_reset_n = 1'b0;
    settle();
    hw_reset_n = 1'b1;
    settle();
    chk_ps(1'b0, "R10 ps cleared");
    expect_out(1'b0, 1'b0, 16'h0, "R10 bus idle");
    async_read(22'h11_0042, "R10 async after reset");
    burst(22'h00_0020, 9, 2, 2'd0, "R10 defaults restored");

    settle();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule